// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of up to six processors owns one shared external bus. Each processor raises a request bit. The arbiter answers with a one-hot grant vector and a bus-owner number, where the number is the processor index plus one and zero means the bus has never been claimed. Software picks the winner-selection scheme at run time. In fixed mode the lowest index wins. In rotating mode the search starts just past the current owner, so the owner that gives up the bus falls to last place.

Three controls shape how long a processor keeps the bus:
- A per-processor lock bit pins ownership for an indivisible read-modify-write.
- A programmable tenure limit forces a handoff after a set number of cycles when someone else is waiting.
- A per-processor core-access flag marks a request as a core access, as opposed to a DMA transfer. A core access displaces an owner whose own tenure is a DMA transfer.

When nobody requests, the last owner stays parked on the bus.

Top module: `mp_bus_arbiter`

## Requirements
- R1: While reset is applied, and after reset until the first request, `grant_o` is all zeros and `owner_id_o` is 0.
- R2: At most one grant bit is set at any time. When `grant_o[i]` is set, `owner_id_o` equals i+1. When no bit is set, `owner_id_o` is 0.
- R3: With `rotate_i`=0, when the owner stops requesting, or no owner exists, the requester with the lowest index wins.
- R4: With `rotate_i`=1, the search starts at owner index + 1 and wraps from 5 to 0, so the previous owner has the lowest priority.
- R5: An owner that keeps requesting keeps the bus unless R8 or R11 applies.
- R6: With no request pending, the current owner keeps its grant (parking).
- R7: While the owner's `lock_i` bit is 1, ownership does not change. This holds against core preemption, against tenure expiry, and when other requests are waiting.
- R8: With `tenure_limit_i`=L≠0 and at least one other requester, an unlocked owner holds the bus for exactly L cycles. The next owner is then chosen among the other requesters, following the active scheme.
- R9: With `tenure_limit_i`=0, no tenure limit applies.
- R10: When the tenure has already run out and no other request is pending, the owner stays. It hands over one cycle after another request appears.
- R11: An unlocked owner whose `core_pri_i` bit is 0 (a DMA tenure) loses the bus in the next cycle to a requester whose `core_pri_i` bit is 1. That requester is chosen among the core requesters by the active scheme.
- R12: An owner whose `core_pri_i` bit is 1 is not preempted by other core requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| tenure_limit_i | input | 8 | Tenure cap in cycles, 0 = no cap |
| req_i | input | 6 | Bus request, one bit per processor |
| lock_i | input | 6 | Lock hold, one bit per processor |
| core_pri_i | input | 6 | 1 = the request is a core access, 0 = a DMA transfer |
| grant_o | output | 6 | One-hot bus grant |
| owner_id_o | output | 3 | Owner index + 1, 0 = no owner |

## Verification
The owner register samples the inputs on one rising edge, and its decoded outputs are valid straight after it. Every ownership decision is therefore visible one clock after the inputs that cause it. The bench drives inputs just after a falling edge and compares both outputs at the next falling edge. The tenure checks count edges from the first grant: the first owner is still present after edge L and the successor is present after edge L+1. After reset is released, the bench waits three edges, because the internal reset synchronizer adds two stages.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // reason for the owner decision in a cycle
  typedef enum logic [2:0] {
    DEC_PARK,
    DEC_KEEP,
    DEC_LOCKED,
    DEC_PREEMPT,
    DEC_EXPIRE,
    DEC_HANDOFF
  } arb_dec_e;

  // selects which candidate mask a picker instance scans
  localparam int PICK_ALL  = 0;
  localparam int PICK_OTH  = 1;
  localparam int PICK_CORE = 2;
  localparam int PICK_NUM  = 3;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
  parameter int N  = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] start_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // scan from start_i upward with wrap; the nearest set bit wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int p;
      p = (int'(start_i) + k) % N;
      if (mask_i[p]) begin
        vld_o = 1'b1;
        idx_o = IW'(p);
      end
    end
  end
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         new_grant_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // cycles the present owner has held the bus, saturating
  always_comb begin
    cnt_en = new_grant_i || (cnt_q != CNT_MAX);
    cnt_d  = new_grant_i ? W'(1) : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);

  a_r8_fresh_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_grant_i |=> (cnt_q == W'(1)));
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter #(
  parameter int N     = 6,
  parameter int LIM_W = 8,
  parameter int IW    = $clog2(N),
  parameter int ID_W  = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rotate_i,
  input  logic [LIM_W-1:0] tenure_limit_i,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     lock_i,
  input  logic [N-1:0]     core_pri_i,
  output logic [N-1:0]     grant_o,
  output logic [ID_W-1:0]  owner_id_o
);
  import arb_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic           rst_n;
  logic [IW-1:0]  owner_q, owner_d;
  logic           owner_vld_q, owner_vld_d;
  logic           own_en;
  logic [N-1:0]   own_oh;
  logic [IW-1:0]  scan_start;
  logic           own_lock, own_req, own_core;
  logic           expired;
  arb_dec_e       dec;

  logic [N-1:0]   pick_mask [PICK_NUM];
  logic           pick_vld  [PICK_NUM];
  logic [IW-1:0]  pick_idx  [PICK_NUM];

  arb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // present owner as one-hot and its control bits
  always_comb begin
    own_oh   = owner_vld_q ? (N'(1) << owner_q) : '0;
    own_lock = owner_vld_q && lock_i[owner_q];
    own_req  = owner_vld_q && req_i[owner_q];
    own_core = core_pri_i[owner_q];
  end

  // rotating scheme starts just past the owner, fixed scheme at zero
  always_comb begin
    scan_start = '0;
    if (rotate_i && owner_vld_q)
      scan_start = (owner_q == LAST_IDX) ? '0 : owner_q + IW'(1);
  end

  always_comb begin
    pick_mask[PICK_ALL]  = req_i;
    pick_mask[PICK_OTH]  = req_i & ~own_oh;
    pick_mask[PICK_CORE] = req_i & core_pri_i & ~own_oh;
  end

  for (genvar g = 0; g < PICK_NUM; g++) begin : g_pick
    arb_rot_pick #(.N(N), .IW(IW)) i_pick (
      .mask_i  (pick_mask[g]),
      .start_i (scan_start),
      .vld_o   (pick_vld[g]),
      .idx_o   (pick_idx[g])
    );
  end

  arb_tenure #(.W(LIM_W)) i_tenure (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .new_grant_i (own_en),
    .limit_i     (tenure_limit_i),
    .expired_o   (expired)
  );

  // ownership decision
  always_comb begin
    dec = DEC_PARK;
    if (own_lock)                                 dec = DEC_LOCKED;
    else if (own_req) begin
      if (!own_core && pick_vld[PICK_CORE])       dec = DEC_PREEMPT;
      else if (expired && pick_vld[PICK_OTH])     dec = DEC_EXPIRE;
      else                                        dec = DEC_KEEP;
    end
    else if (pick_vld[PICK_ALL])                  dec = DEC_HANDOFF;
  end

  always_comb begin
    owner_d     = owner_q;
    owner_vld_d = owner_vld_q;
    unique case (dec)
      DEC_PREEMPT: begin owner_d = pick_idx[PICK_CORE]; owner_vld_d = 1'b1; end
      DEC_EXPIRE:  begin owner_d = pick_idx[PICK_OTH];  owner_vld_d = 1'b1; end
      DEC_HANDOFF: begin owner_d = pick_idx[PICK_ALL];  owner_vld_d = 1'b1; end
      default:     ;
    endcase
    own_en = (owner_vld_d != owner_vld_q) || (owner_d != owner_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      owner_q     <= '0;
      owner_vld_q <= 1'b0;
    end else if (own_en) begin
      owner_q     <= owner_d;
      owner_vld_q <= owner_vld_d;
    end
  end

  assign grant_o    = own_oh;
  assign owner_id_o = owner_vld_q ? ID_W'(owner_q) + ID_W'(1) : '0;

  // ---------------- assertions ----------------
  a_r2_single_grant: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r2_id_agrees: assert property (@(posedge clk_i) disable iff (!rst_n)
    (owner_id_o == '0) == (grant_o == '0));

  a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (owner_vld_q && lock_i[owner_q]) |=> (owner_vld_q && owner_q == $past(owner_q)));

  a_r6_parked: assert property (@(posedge clk_i) disable iff (!rst_n)
    (owner_vld_q && req_i == '0) |=> (owner_vld_q && owner_q == $past(owner_q)));

  a_r8_expiry_hands_over: assert property (@(posedge clk_i) disable iff (!rst_n)
    (owner_vld_q && !lock_i[owner_q] && req_i[owner_q] && expired && (req_i & ~own_oh) != '0)
      |=> (owner_q != $past(owner_q)));

  a_r12_core_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
    (owner_vld_q && req_i[owner_q] && core_pri_i[owner_q] && !expired)
      |=> (owner_q == $past(owner_q)));
endmodule

// File: tb/test_mp_bus_arbiter.sv
module test_mp_bus_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rotate_i;
  logic [7:0] tenure_limit_i;
  logic [5:0] req_i, lock_i, core_pri_i;
  logic [5:0] grant_o;
  logic [2:0] owner_id_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  mp_bus_arbiter i_mp_bus_arbiter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rotate_i       (rotate_i),
    .tenure_limit_i (tenure_limit_i),
    .req_i          (req_i),
    .lock_i         (lock_i),
    .core_pri_i     (core_pri_i),
    .grant_o        (grant_o),
    .owner_id_o     (owner_id_o)
  );

  // {rotate, limit, req, lock, core, expected id after one edge}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 8'd0, 6'b000000, 6'b000000, 6'b000000, 3'd0}, // R1 no request yet
    {1'b0, 8'd0, 6'b101000, 6'b000000, 6'b000000, 3'd4}, // R3 lowest wins
    {1'b0, 8'd0, 6'b101001, 6'b000000, 6'b000000, 3'd4}, // R5 owner keeps
    {1'b0, 8'd0, 6'b100001, 6'b000000, 6'b000000, 3'd1}, // R3 handoff lowest
    {1'b0, 8'd0, 6'b000000, 6'b000000, 6'b000000, 3'd1}, // R6 park
    {1'b0, 8'd0, 6'b110000, 6'b000000, 6'b000000, 3'd5}, // R3 from park
    {1'b1, 8'd0, 6'b100001, 6'b000000, 6'b000000, 3'd6}, // R4 past owner
    {1'b1, 8'd0, 6'b000011, 6'b000000, 6'b000000, 3'd1}, // R4 wrap
    {1'b1, 8'd0, 6'b000110, 6'b000000, 6'b000000, 3'd2}, // R4
    {1'b1, 8'd0, 6'b000101, 6'b000000, 6'b000000, 3'd3}, // R4 skips bit0
    {1'b1, 8'd0, 6'b000101, 6'b000100, 6'b000001, 3'd3}, // R7 lock vs core
    {1'b1, 8'd0, 6'b000101, 6'b000000, 6'b000001, 3'd1}, // R11 preempt
    {1'b1, 8'd0, 6'b000101, 6'b000000, 6'b000101, 3'd1}, // R12 core kept
    {1'b1, 8'd0, 6'b001101, 6'b000000, 6'b001100, 3'd3}  // R11 rotating pick
  };

  function automatic logic [5:0] grant_of(input logic [2:0] id);
    return (id == 3'd0) ? 6'd0 : (6'd1 << (id - 3'd1));
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp_id);
    total++;
    if (owner_id_o !== exp_id || grant_o !== grant_of(exp_id)) begin
      bad++;
      $display("FAIL %s: id=%0d grant=%b expected id=%0d grant=%b",
               tag, owner_id_o, grant_o, exp_id, grant_of(exp_id));
    end
  endtask

  task automatic drive(input logic rot, input logic [7:0] lim, input logic [5:0] rq,
                       input logic [5:0] lk, input logic [5:0] cp);
    rotate_i = rot; tenure_limit_i = lim; req_i = rq; lock_i = lk; core_pri_i = cp;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    drive(1'b0, 8'd0, 6'd0, 6'd0, 6'd0);
    repeat (2) @(negedge clk_i);
    chk("R1 in reset", 3'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    drive(1'b0, 8'd0, 6'd0, 6'd0, 6'd0);
    do_reset();
    chk("R1 after reset", 3'd0);

    // vector table, R2 grant/id agreement checked on every entry
    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      e = VEC[v];
      drive(e[29], e[28:21], e[20:15], e[14:9], e[8:3]);
      @(negedge clk_i);
      chk($sformatf("R2 vector %0d", v), e[2:0]);
    end

    // R8: limit 3, processors 0 and 1 both requesting
    do_reset();
    drive(1'b0, 8'd3, 6'b000011, 6'd0, 6'd0);
    for (int s = 1; s <= 7; s++) begin
      @(negedge clk_i);
      if (s == 3) chk("R8 held L cycles", 3'd1);
      if (s == 4) chk("R8 handover after L", 3'd2);
      if (s == 6) chk("R8 successor held", 3'd2);
      if (s == 7) chk("R8 handback", 3'd1);
    end

    // R10: expired with nobody waiting, then a waiter appears
    do_reset();
    drive(1'b0, 8'd2, 6'b000001, 6'd0, 6'd0);
    repeat (5) @(negedge clk_i);
    chk("R10 stays when alone", 3'd1);
    drive(1'b0, 8'd2, 6'b000011, 6'd0, 6'd0);
    @(negedge clk_i);
    chk("R10 hands over next cycle", 3'd2);

    // R9: limit zero never forces a handover
    do_reset();
    drive(1'b0, 8'd0, 6'b000011, 6'd0, 6'd0);
    repeat (10) @(negedge clk_i);
    chk("R9 no limit", 3'd1);

    // R7: lock overrides tenure expiry
    do_reset();
    drive(1'b0, 8'd2, 6'b000011, 6'b000001, 6'd0);
    repeat (6) @(negedge clk_i);
    chk("R7 lock beats tenure", 3'd1);
    drive(1'b0, 8'd2, 6'b000011, 6'd0, 6'd0);
    @(negedge clk_i);
    chk("R7 release then expiry", 3'd2);

    finish_run();
  end
endmodule